// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block carries out the hardware part of taking an exception on a small 32-bit core. It handles three causes: a software break trap, an MMU or bus fault, and an external interrupt. When a cause is accepted, the block captures the core state presented at its inputs. From that state it works out the saved return address and the shifted status word. It also decides whether the user and kernel stack pointers must be swapped.

It then reads the handler start address from a vector table through a simple request/valid read port. In one commit cycle it presents the new PC, the return address, the status word and the stack registers, together with a one-cycle done strobe and a delay-slot clear strobe. The core loads these values on that strobe.

A fault request that arrives while a fault entry is still in progress is a recursive fault. The block does not re-enter. Instead it raises a fatal flag that stays high until reset.

Top module: `exc_entry_seq`

## Requirements
- R1: A break trap saves a return address of pc_i + 2 (minus the delay-slot size) and indexes the vector table with trap_vec_i.
- R2: A fault saves a return address of pc_i (minus the delay-slot size) and indexes the table with fault_vec_i.
- R3: An interrupt is accepted only when status_i bit IE_BIT (default 4) is 1. Its return address is pc_i (minus the delay-slot size) and its index is irq_vec_i. With that bit at 0 the request is ignored: no done pulse occurs and every output keeps its value.
- R4: A nonzero dslot_i is subtracted from the saved return address. dslot_clr_o pulses in the same cycle as done_o.
- R5: The handler read uses the address base_i + 4 × vector, and pc_o is loaded with the word returned by the read.
- R6: When status_i bit U_BIT (default 5) is 1, usp_o takes sp_i and sp_o takes ksp_i. Otherwise sp_o takes sp_i and usp_o takes usp_i.
- R7: status_o is built from three parts: bits [31:30] are the old bits [31:30], bits [29:10] are the old bits [19:0], and bits [9:0] are zero. The user flag therefore reads 0 after entry.
- R8: When several causes are pending in the same cycle, a fault wins over a break, and a break wins over an interrupt.
- R9: A fault request that arrives while a fault entry is in progress sets fatal_o, which stays 1 until reset. A break request that arrives during a break entry does not set fatal_o.
- R10: mem_req_o rises two cycles after the accepting edge and stays high until mem_valid_i is seen. done_o is high for exactly the one cycle after that. The result outputs change only in the done cycle.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_fault_i | input | 1 | MMU/bus fault request (sampled while idle) |
| req_break_i | input | 1 | Break trap request |
| req_irq_i | input | 1 | External interrupt request |
| fault_vec_i | input | 8 | Fault vector index |
| trap_vec_i | input | 8 | Break vector index |
| irq_vec_i | input | 8 | Interrupt vector from the interrupt controller |
| pc_i | input | 32 | Current PC |
| dslot_i | input | 2 | Delay-slot size, 0 when not in a slot |
| status_i | input | 32 | Current status word |
| base_i | input | 32 | Vector table base |
| sp_i | input | 32 | Current stack pointer |
| usp_i | input | 32 | Current user stack pointer |
| ksp_i | input | 32 | Kernel stack pointer |
| mem_req_o | output | 1 | Vector read request |
| mem_addr_o | output | 32 | Vector read address |
| mem_valid_i | input | 1 | Read data valid |
| mem_data_i | input | 32 | Read data (handler address) |
| done_o | output | 1 | One-cycle commit strobe |
| dslot_clr_o | output | 1 | Delay-slot clear strobe |
| fatal_o | output | 1 | Recursive fault flag, sticky |
| pc_o | output | 32 | New PC (handler address) |
| ret_addr_o | output | 32 | Saved return address |
| status_o | output | 32 | Shifted status word |
| sp_o | output | 32 | New stack pointer |
| usp_o | output | 32 | New user stack pointer |

## Verification
Some properties are checked by the assertions on every cycle:
- done is a single-cycle pulse that always follows an accepted read.
- The result registers hold their value outside the done cycle.
- A committed status word never carries low bits or the user flag.
- The fatal flag never drops, and the read address stays steady while a read is outstanding.
- A fault request always wins the arbitration, and a granted interrupt always has its enable bit set.

Other behaviour can only be shown by the bench scenarios, because it depends on the values presented at entry:
- the exact return-address arithmetic for each cause and delay-slot size;
- the choice of vector table entry;
- the stack swap against the user flag;
- the masked-interrupt case, where nothing happens;
- the recursive fault and the reset values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_READ, ST_COMMIT} seq_state_e;
  typedef enum logic [1:0] {CZ_NONE, CZ_FAULT, CZ_BREAK, CZ_IRQ} cause_e;
endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
  import exc_entry_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic             req_fault_i,
  input  logic             req_break_i,
  input  logic             req_irq_i,
  input  logic             irq_en_i,
  input  logic [VEC_W-1:0] fault_vec_i,
  input  logic [VEC_W-1:0] trap_vec_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  output cause_e           cause_o,
  output logic [VEC_W-1:0] vec_o
);
  // fault > break > interrupt; a masked interrupt is not a cause
  always_comb begin
    cause_o = CZ_NONE;
    vec_o   = '0;
    if (req_fault_i) begin
      cause_o = CZ_FAULT;
      vec_o   = fault_vec_i;
    end else if (req_break_i) begin
      cause_o = CZ_BREAK;
      vec_o   = trap_vec_i;
    end else if (req_irq_i && irq_en_i) begin
      cause_o = CZ_IRQ;
      vec_o   = irq_vec_i;
    end
  end

  always_comb begin
    if (req_fault_i) p_fault_wins_r8: assert (cause_o == CZ_FAULT);
    if (cause_o == CZ_IRQ) p_irq_enabled_r3: assert (irq_en_i && !req_break_i);
  end
endmodule

// File: rtl/exc_frame_calc.sv
module exc_frame_calc
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned DSLOT_W  = 2,
  parameter int unsigned U_BIT    = 5,
  parameter int unsigned KEEP_HI  = 2,
  parameter int unsigned SHIFT    = 10,
  parameter int unsigned BRK_STEP = 2
) (
  input  cause_e            cause_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [DSLOT_W-1:0] dslot_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [XLEN-1:0]   sp_i,
  input  logic [XLEN-1:0]   usp_i,
  input  logic [XLEN-1:0]   ksp_i,
  output logic [XLEN-1:0]   ret_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   sp_o,
  output logic [XLEN-1:0]   usp_o,
  output logic [XLEN-1:0]   vec_addr_o
);
  localparam int unsigned LOW_W = XLEN - KEEP_HI - SHIFT;

  logic [XLEN-1:0] ret_base;
  logic            user_mode;
  logic            unused_mid;

  assign unused_mid = ^status_i[XLEN-KEEP_HI-1:LOW_W];
  assign user_mode  = status_i[U_BIT];

  // break resumes after the trap instruction; others retry it
  assign ret_base   = pc_i + ((cause_i == CZ_BREAK) ? XLEN'(BRK_STEP) : '0);
  // a delay-slot instruction restarts at its branch
  assign ret_o      = ret_base - XLEN'(dslot_i);

  assign status_o   = {status_i[XLEN-1 -: KEEP_HI], status_i[LOW_W-1:0], {SHIFT{1'b0}}};

  assign sp_o       = user_mode ? ksp_i : sp_i;
  assign usp_o      = user_mode ? sp_i  : usp_i;

  assign vec_addr_o = base_i + (XLEN'(vec_i) << 2);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned DSLOT_W = 2,
  parameter int unsigned IE_BIT  = 4,
  parameter int unsigned U_BIT   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_fault_i,
  input  logic               req_break_i,
  input  logic               req_irq_i,
  input  logic [VEC_W-1:0]   fault_vec_i,
  input  logic [VEC_W-1:0]   trap_vec_i,
  input  logic [VEC_W-1:0]   irq_vec_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [DSLOT_W-1:0] dslot_i,
  input  logic [XLEN-1:0]    status_i,
  input  logic [XLEN-1:0]    base_i,
  input  logic [XLEN-1:0]    sp_i,
  input  logic [XLEN-1:0]    usp_i,
  input  logic [XLEN-1:0]    ksp_i,
  output logic               mem_req_o,
  output logic [XLEN-1:0]    mem_addr_o,
  input  logic               mem_valid_i,
  input  logic [XLEN-1:0]    mem_data_i,
  output logic               done_o,
  output logic               dslot_clr_o,
  output logic               fatal_o,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    ret_addr_o,
  output logic [XLEN-1:0]    status_o,
  output logic [XLEN-1:0]    sp_o,
  output logic [XLEN-1:0]    usp_o
);
  localparam int unsigned SHIFT = 10;

  seq_state_e         state_q;
  cause_e             cause_w, cause_q;
  logic [VEC_W-1:0]   vec_w, vec_q;
  logic [XLEN-1:0]    pc_q, status_q, base_q, sp_q, usp_q, ksp_q, addr_q;
  logic [DSLOT_W-1:0] dslot_q;
  logic [XLEN-1:0]    ret_w, st_w, sp_w, usp_w, vaddr_w;
  logic               fatal_q;

  exc_cause_arb #(.VEC_W(VEC_W)) u_arb (
    .req_fault_i (req_fault_i),
    .req_break_i (req_break_i),
    .req_irq_i   (req_irq_i),
    .irq_en_i    (status_i[IE_BIT]),
    .fault_vec_i (fault_vec_i),
    .trap_vec_i  (trap_vec_i),
    .irq_vec_i   (irq_vec_i),
    .cause_o     (cause_w),
    .vec_o       (vec_w)
  );

  exc_frame_calc #(
    .XLEN(XLEN), .VEC_W(VEC_W), .DSLOT_W(DSLOT_W), .U_BIT(U_BIT),
    .KEEP_HI(2), .SHIFT(SHIFT), .BRK_STEP(2)
  ) u_frame (
    .cause_i    (cause_q),
    .pc_i       (pc_q),
    .dslot_i    (dslot_q),
    .status_i   (status_q),
    .base_i     (base_q),
    .vec_i      (vec_q),
    .sp_i       (sp_q),
    .usp_i      (usp_q),
    .ksp_i      (ksp_q),
    .ret_o      (ret_w),
    .status_o   (st_w),
    .sp_o       (sp_w),
    .usp_o      (usp_w),
    .vec_addr_o (vaddr_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cause_q    <= CZ_NONE;
      vec_q      <= '0;
      pc_q       <= '0;
      dslot_q    <= '0;
      status_q   <= '0;
      base_q     <= '0;
      sp_q       <= '0;
      usp_q      <= '0;
      ksp_q      <= '0;
      addr_q     <= '0;
      pc_o       <= '0;
      ret_addr_o <= '0;
      status_o   <= '0;
      sp_o       <= '0;
      usp_o      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cause_w != CZ_NONE) begin
            cause_q  <= cause_w;
            vec_q    <= vec_w;
            pc_q     <= pc_i;
            dslot_q  <= dslot_i;
            status_q <= status_i;
            base_q   <= base_i;
            sp_q     <= sp_i;
            usp_q    <= usp_i;
            ksp_q    <= ksp_i;
            state_q  <= ST_CALC;
          end
        end
        ST_CALC: begin
          addr_q  <= vaddr_w;
          state_q <= ST_READ;
        end
        ST_READ: begin
          if (mem_valid_i) begin
            pc_o       <= mem_data_i;
            ret_addr_o <= ret_w;
            status_o   <= st_w;
            sp_o       <= sp_w;
            usp_o      <= usp_w;
            state_q    <= ST_COMMIT;
          end
        end
        ST_COMMIT: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // a second fault during fault entry is unrecoverable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fatal_q <= 1'b0;
    else if (state_q != ST_IDLE && cause_q == CZ_FAULT && req_fault_i) fatal_q <= 1'b1;
  end

  assign fatal_o     = fatal_q;
  assign done_o      = (state_q == ST_COMMIT);
  assign dslot_clr_o = done_o;
  assign mem_req_o   = (state_q == ST_READ);
  assign mem_addr_o  = addr_q;

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_valid_i));
  p_outputs_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(ret_addr_o) && $stable(pc_o) && $stable(sp_o) && $stable(status_o)));
  p_status_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (status_o[SHIFT-1:0] == '0 && !status_o[U_BIT]));
  p_fatal_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
  p_addr_steady_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  typedef struct {
    logic [31:0] ret;
    logic [31:0] addr;
    logic [31:0] status;
    logic [31:0] sp;
    logic [31:0] usp;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_fault = 0, req_break = 0, req_irq = 0;
  logic [7:0]  fault_vec = 0, trap_vec = 0, irq_vec = 0;
  logic [31:0] pc = 0, status = 0, base = 0, sp = 0, usp = 0, ksp = 0;
  logic [1:0]  dslot = 0;
  logic        mem_req, mem_valid = 0, done, dslot_clr, fatal;
  logic [31:0] mem_addr, mem_data = 0;
  logic [31:0] pc_o, ret_o, status_o, sp_o, usp_o;

  int checks = 0, failures = 0, cycles = 0, mem_lat = 0, wait_cnt = 0;
  exp_t q[$];
  exp_t last_exp;

  always #5 clk = ~clk;

  exc_entry_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_fault_i(req_fault), .req_break_i(req_break), .req_irq_i(req_irq),
    .fault_vec_i(fault_vec), .trap_vec_i(trap_vec), .irq_vec_i(irq_vec),
    .pc_i(pc), .dslot_i(dslot), .status_i(status), .base_i(base),
    .sp_i(sp), .usp_i(usp), .ksp_i(ksp),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_data_i(mem_data),
    .done_o(done), .dslot_clr_o(dslot_clr), .fatal_o(fatal),
    .pc_o(pc_o), .ret_addr_o(ret_o), .status_o(status_o), .sp_o(sp_o), .usp_o(usp_o)
  );

  function automatic logic [31:0] handler_of(input logic [31:0] a);
    return (a << 1) ^ 32'h8000_1234;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers after mem_lat idle cycles
  always @(negedge clk) begin
    if (mem_valid) mem_valid = 1'b0;
    else if (mem_req) begin
      if (wait_cnt >= mem_lat) begin
        mem_valid = 1'b1;
        mem_data  = handler_of(mem_addr);
        wait_cnt  = 0;
      end else wait_cnt++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        chk(0, "R3 unexpected done", {31'b0, done}, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(ret_o == e.ret, e.tag, ret_o, e.ret);
        chk(pc_o == handler_of(e.addr), "R5 handler pc", pc_o, handler_of(e.addr));
        chk(status_o == e.status, "R7 status", status_o, e.status);
        chk(sp_o == e.sp, "R6 sp", sp_o, e.sp);
        chk(usp_o == e.usp, "R6 usp", usp_o, e.usp);
        chk(dslot_clr == 1'b1, "R4 dslot clear", {31'b0, dslot_clr}, 32'h1);
        last_exp = e;
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic entry(input bit f, input bit b, input bit i, input logic [31:0] pc_v,
                       input logic [1:0] ds, input logic [31:0] st, input logic [31:0] base_v,
                       input logic [31:0] sp_v, input logic [31:0] usp_v, input logic [31:0] ksp_v,
                       input logic [7:0] fv, input logic [7:0] tv, input logic [7:0] iv,
                       input int lat, input bit again, input string tag);
    bit   taken;
    logic [7:0] vec;
    logic [31:0] step;
    exp_t e;
    taken = f || b || (i && st[4]);
    vec   = f ? fv : (b ? tv : iv);
    step  = (!f && b) ? 32'd2 : 32'd0;
    e.ret    = pc_v + step - {30'b0, ds};
    e.addr   = base_v + {22'b0, vec, 2'b00};
    e.status = {st[31:30], st[19:0], 10'b0};
    e.sp     = st[5] ? ksp_v : sp_v;
    e.usp    = st[5] ? sp_v : usp_v;
    e.tag    = tag;
    if (taken) q.push_back(e);
    mem_lat = lat;
    @(negedge clk);
    req_fault = f; req_break = b; req_irq = i;
    fault_vec = fv; trap_vec = tv; irq_vec = iv;
    pc = pc_v; dslot = ds; status = st; base = base_v;
    sp = sp_v; usp = usp_v; ksp = ksp_v;
    @(negedge clk);
    req_fault = 0; req_break = 0; req_irq = 0;
    if (taken) begin
      chk(mem_req == 1'b0, "R10 no read in calc", {31'b0, mem_req}, 32'h0);
      @(negedge clk);
      chk(mem_req == 1'b1, "R10 read two cycles after accept", {31'b0, mem_req}, 32'h1);
      chk(mem_addr == e.addr, "R5 vector address", mem_addr, e.addr);
      if (again) begin
        req_fault = f; req_break = b;
        @(negedge clk);
        req_fault = 0; req_break = 0;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(done == 1'b0, "R10 done single cycle", {31'b0, done}, 32'h0);
    end else begin
      repeat (8) @(negedge clk);
      chk(ret_o == last_exp.ret, "R3 masked irq keeps ret", ret_o, last_exp.ret);
      chk(pc_o == handler_of(last_exp.addr), "R3 masked irq keeps pc", pc_o, handler_of(last_exp.addr));
      chk(mem_req == 1'b0, "R3 masked irq no read", {31'b0, mem_req}, 32'h0);
    end
  endtask

  task automatic check_reset(input string tag);
    chk(done == 0 && mem_req == 0 && fatal == 0 && dslot_clr == 0, tag,
        {29'b0, done, mem_req, fatal}, 32'h0);
    chk(pc_o == 0 && ret_o == 0 && status_o == 0 && sp_o == 0 && usp_o == 0, tag,
        pc_o | ret_o | status_o | sp_o | usp_o, 32'h0);
  endtask

  initial begin
    last_exp.ret = 0; last_exp.addr = 0; last_exp.status = 0;
    last_exp.sp = 0; last_exp.usp = 0; last_exp.tag = "";
    repeat (3) @(negedge clk);
    check_reset("R11 reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    // R1 break, kernel mode
    entry(0, 1, 0, 32'h0000_1000, 2'd0, 32'h0000_0010, 32'h0002_0000, 32'hA0, 32'hB0, 32'hC0,
          8'h11, 8'h22, 8'h33, 0, 0, "R1 break ret");
    // R2 fault from user mode, stacks swap (R6)
    entry(1, 0, 0, 32'h0000_2004, 2'd0, 32'h0000_0020, 32'h0003_0000, 32'h100, 32'h200, 32'h300,
          8'h05, 8'h06, 8'h07, 2, 0, "R2 fault ret");
    // R3 interrupt enabled
    entry(0, 0, 1, 32'h0000_3008, 2'd0, 32'h0000_0010, 32'h0004_0000, 32'h400, 32'h500, 32'h600,
          8'h01, 8'h02, 8'hFF, 1, 0, "R3 irq ret");
    // R3 interrupt masked
    entry(0, 0, 1, 32'h0000_4000, 2'd0, 32'h0000_0020, 32'h0005_0000, 32'h1, 32'h2, 32'h3,
          8'h01, 8'h02, 8'h44, 0, 0, "R3 masked");
    // R4 break in delay slot, user mode
    entry(0, 1, 0, 32'h0000_5010, 2'd2, 32'h0000_0030, 32'h0006_0000, 32'h700, 32'h800, 32'h900,
          8'h09, 8'h0A, 8'h0B, 3, 0, "R4 break dslot ret");
    // R4 fault in delay slot
    entry(1, 0, 0, 32'h0000_6020, 2'd2, 32'h0000_0000, 32'h0006_0000, 32'h10, 32'h20, 32'h30,
          8'h0C, 8'h0D, 8'h0E, 0, 0, "R4 fault dslot ret");
    // R8 all three pending: fault wins
    entry(1, 1, 1, 32'h0000_7000, 2'd0, 32'h0000_0010, 32'h0007_0000, 32'h11, 32'h22, 32'h33,
          8'h40, 8'h50, 8'h60, 1, 0, "R8 fault over break/irq");
    // R8 break over enabled irq
    entry(0, 1, 1, 32'h0000_8000, 2'd0, 32'h0000_0010, 32'h0008_0000, 32'h44, 32'h55, 32'h66,
          8'h41, 8'h51, 8'h61, 0, 0, "R8 break over irq");
    // R7 dense status pattern, user flag set
    entry(0, 1, 0, 32'h0000_9000, 2'd1, 32'hFFFF_FFFF, 32'h0009_0000, 32'h77, 32'h88, 32'h99,
          8'h00, 8'hFE, 8'h00, 0, 0, "R7 status pattern ret");
    // R9 break during break: no fatal
    entry(0, 1, 0, 32'h0000_A000, 2'd0, 32'h0000_0000, 32'h000A_0000, 32'h1, 32'h2, 32'h3,
          8'h00, 8'h12, 8'h00, 3, 1, "R9 break again ret");
    chk(fatal == 1'b0, "R9 no fatal on break", {31'b0, fatal}, 32'h0);
    // R9 fault during fault: fatal
    entry(1, 0, 0, 32'h0000_B000, 2'd0, 32'h0000_0000, 32'h000B_0000, 32'h1, 32'h2, 32'h3,
          8'h13, 8'h00, 8'h00, 3, 1, "R9 fault again ret");
    chk(fatal == 1'b1, "R9 fatal on recursive fault", {31'b0, fatal}, 32'h1);
    repeat (4) @(negedge clk);
    chk(fatal == 1'b1, "R9 fatal sticky", {31'b0, fatal}, 32'h1);
    chk(q.size() == 0, "R10 all entries committed", q.size(), 32'h0);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset("R11 reset after run");
    finish_run();
  end
endmodule